// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host read and write a processor's on-chip program and data memory without involving the core. The host drives a 16-bit bus that is shared between address and data, plus four strobes: select, address latch, read and write. All strobes and the bus are brought into the core clock domain through a synchronizer. Edges are detected only after synchronization. Each data transfer becomes a single-cycle request on the memory side. That request carries the memory space, the current word address and the current overlay number.

The host first sends a setup word, which is latched when the address-latch strobe falls while select is high. The top bit of the setup word chooses what it means. It either sets a start address together with a space flag, or it sets the overlay number. After that, the host streams words, and the port steps the address after each complete word. Program memory words are 24 bits wide and take two host transfers each. A window of addresses in data space is reserved for control registers and is never reached from the host side. An acknowledge output goes low while a transfer is in progress and returns high when the transfer is done.

Top module: `hmap_port`

## Requirements
- R1: After reset, host_ack is 1, mem_req is 0, host_bus_out is 0, mem_addr is 0, mem_space is 0 (data) and mem_ovl is 0.
- R2: A setup word with bit 15 = 0 loads bits 13:0 into the word address and bit 14 into the space flag (1 = program, 0 = data). The load happens on the synchronized falling edge of host_latch while host_sel is high, and host_ack is left unchanged.
- R3: A setup word with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into mem_ovl and leaves the address unchanged. If bits 14:8 are not all zero, the whole word has no effect.
- R4: Strobe timing: when host_wr (or host_rd) rises while host_sel is high, a memory access, when the transfer makes one, has mem_req high for exactly one cycle. That cycle begins at the second clock edge after the first edge that samples the strobe high.
- R5: host_ack falls at the same edge where mem_req rises. For a write it rises one edge later. For a read it rises two edges later, and host_bus_out holds the read data from that edge on.
- R6: In data space, every completed transfer increments the 14-bit address by one, wrapping from 0x3FFF to 0. A data write puts {8'h00, bus} on mem_wdata.
- R7: A program-space write takes two transfers. The first holds bus bits 15:0 as word bits 23:8 and makes no request. The second writes {held, bus[7:0]} with mem_we = 1, then increments the address.
- R8: A program-space read takes two transfers. The first reads memory and returns word bits 23:8. The second makes no request, returns {8'h00, word bits 7:0}, then increments the address.
- R9: A data-space access whose address lies in 0x3FE0..0x3FFF makes no memory request. A read of that window returns 0, and the address still increments and acknowledge still cycles.
- R10: Read and write strobes while host_sel is low have no effect: they make no request and no address change.
- R11: Any setup word accepted at the address stage makes the next program-space transfer the first half of a word again.
- R12: mem_we is 1 during a request made by a write and 0 during a request made by a read, and mem_space and mem_ovl carry the latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host select, asynchronous |
| host_latch | input | 1 | Host address-latch strobe, asynchronous |
| host_rd | input | 1 | Host read strobe, asynchronous |
| host_wr | input | 1 | Host write strobe, asynchronous |
| host_bus_in | input | 16 | Shared address/data bus from the host |
| host_bus_out | output | 16 | Read data toward the host |
| host_bus_oe | output | 1 | Drive enable for the host bus during a host read |
| host_ack | output | 1 | 1 = ready, 0 = transfer in progress |
| mem_req | output | 1 | Single-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_space | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr | output | 14 | Word address |
| mem_ovl | output | 8 | Overlay number |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, valid the cycle after the request |

## Verification
The bench goes after the two-transfer program word. A design that stepped the address after the first half, or that wrote memory with only the upper part held, would return rotated words when they are read back. Setup words are sent in the middle of a half-finished program word, so a design that keeps the half flag across a new setup word would pair the wrong halves. The bench walks writes across the boundary into the reserved control window and through the wrap at the top of the address space. A leaking request or a missing increment shows up there as an extra mem_req pulse, wrong read-back data or a frozen address. It also sends an overlay word with stray high bits and strobes without select, where a design that decodes too loosely would change mem_ovl or issue requests.

// File: rtl/hmap_pkg.sv
`timescale 1ns/1ps
package hmap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_RDW  = 2'd2
   } hmap_state_e;

   typedef struct packed {
      logic sel;
      logic latch;
      logic rd;
      logic wr;
   } hmap_strb_t;
endpackage

// File: rtl/hmap_sync.sv
`timescale 1ns/1ps
module hmap_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hmap_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hmap_addr.sv
`timescale 1ns/1ps
module hmap_addr #(
   parameter int AW = 14,
   parameter int DW = 16,
   parameter int OW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] word,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          space,
   output logic [OW-1:0] ovl
);
   localparam int SEL_BIT   = DW - 1;
   localparam int SPACE_BIT = DW - 2;

   logic pick_ovl;
   logic ovl_clean;

   generate
      if (AW > DW - 2) begin : g_bad_aw
         $error("hmap_addr: AW must leave room for the space and select bits");
      end
      if (OW > DW - 2) begin : g_bad_ow
         $error("hmap_addr: OW too wide for the setup word");
      end
   endgenerate

   assign pick_ovl  = word[SEL_BIT];
   assign ovl_clean = (word[SPACE_BIT:OW] == '0);

   // R2 R3: setup word decode; R6: step after a completed word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         space <= 1'b0;
         ovl   <= '0;
      end else if (load) begin
         if (!pick_ovl) begin
            addr  <= word[AW-1:0];
            space <= word[SPACE_BIT];
         end else if (ovl_clean) begin
            ovl <= word[OW-1:0];
         end
      end else if (inc) begin
         addr <= addr + 1'b1;
      end
   end
endmodule

// File: rtl/hmap_ctrl.sv
`timescale 1ns/1ps
module hmap_ctrl
   import hmap_pkg::*;
#(
   parameter int          AW       = 14,
   parameter int          DW       = 16,
   parameter int          PW       = 24,
   parameter bit          GUARD_EN = 1'b1,
   parameter logic [AW-1:0] CTRL_LO = 14'h3FE0,
   parameter logic [AW-1:0] CTRL_HI = 14'h3FFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_rd,
   input  logic          ev_wr,
   input  logic          clr_phase,
   input  logic [DW-1:0] bus_word,
   input  logic          space,
   input  logic [AW-1:0] addr,
   input  logic [PW-1:0] mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [PW-1:0] mem_wdata,
   output logic          inc,
   output logic          ack,
   output logic [DW-1:0] dout
);
   localparam int LW = PW - DW;

   hmap_state_e   state;
   logic          is_wr;
   logic [DW-1:0] wbuf;
   logic [DW-1:0] hold;
   logic [LW-1:0] lo;
   logic          phase;
   logic          ctrl_hit;
   logic          need;
   logic          last;

   generate
      if (LW < 1 || LW > DW) begin : g_bad_pw
         $error("hmap_ctrl: PW must lie between DW+1 and 2*DW");
      end
      if (GUARD_EN) begin : g_guard
         assign ctrl_hit = !space && (addr >= CTRL_LO) && (addr <= CTRL_HI); // R9
      end else begin : g_noguard
         assign ctrl_hit = 1'b0;
      end
   endgenerate

   // R7 R8: program words need memory on write-second / read-first halves
   always_comb begin
      last = !space || phase;
      if (ctrl_hit)   need = 1'b0;
      else if (!space) need = 1'b1;
      else            need = is_wr ? phase : !phase;
   end

   assign mem_req   = (state == ST_ACC) && need;
   assign mem_we    = is_wr;
   assign mem_wdata = space ? {hold, wbuf[LW-1:0]} : {{LW{1'b0}}, wbuf};
   assign inc       = (state == ST_ACC) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         is_wr <= 1'b0;
         wbuf  <= '0;
         hold  <= '0;
         lo    <= '0;
         phase <= 1'b0;
         ack   <= 1'b1;
         dout  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (clr_phase) phase <= 1'b0;                    // R11
               if (ev_wr || ev_rd) begin
                  state <= ST_ACC;
                  is_wr <= ev_wr;
                  wbuf  <= bus_word;
                  ack   <= 1'b0;                                // R5
               end
            end
            ST_ACC: begin
               if (space) begin
                  phase <= !phase;
                  if (is_wr && !phase) hold <= wbuf;
               end
               if (!is_wr && need) begin
                  state <= ST_RDW;
               end else begin
                  if (!is_wr) dout <= ctrl_hit ? '0 : {{(DW-LW){1'b0}}, lo};
                  ack   <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_RDW: begin
               dout  <= space ? mem_rdata[PW-1:LW] : mem_rdata[DW-1:0];
               lo    <= mem_rdata[LW-1:0];
               ack   <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hmap_port.sv
`timescale 1ns/1ps
module hmap_port
   import hmap_pkg::*;
#(
   parameter int            AW          = 14,
   parameter int            DW          = 16,
   parameter int            PW          = 24,
   parameter int            OW          = 8,
   parameter int            SYNC_STAGES = 2,
   parameter bit            GUARD_EN    = 1'b1,
   parameter logic [AW-1:0] CTRL_LO     = 14'h3FE0,
   parameter logic [AW-1:0] CTRL_HI     = 14'h3FFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_latch,
   input  logic          host_rd,
   input  logic          host_wr,
   input  logic [DW-1:0] host_bus_in,
   output logic [DW-1:0] host_bus_out,
   output logic          host_bus_oe,
   output logic          host_ack,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_space,
   output logic [AW-1:0] mem_addr,
   output logic [OW-1:0] mem_ovl,
   output logic [PW-1:0] mem_wdata,
   input  logic [PW-1:0] mem_rdata
);
   localparam int SW = $bits(hmap_strb_t);

   hmap_strb_t    strb_raw, strb_s, strb_p;
   logic [DW-1:0] bus_s;
   logic          ev_latch, ev_rd, ev_wr, inc;
   logic [AW-1:0] cur_addr;

   assign strb_raw = '{sel: host_sel, latch: host_latch, rd: host_rd, wr: host_wr};

   // R4: strobes and bus share one synchronizer so the word lines up with its edge
   hmap_sync #(.W(SW + DW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({strb_raw, host_bus_in}),
      .q    ({strb_s, bus_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_p <= '0;
      else        strb_p <= strb_s;
   end

   // R10: every event needs the synchronized select
   assign ev_latch = strb_s.sel && strb_p.latch && !strb_s.latch;
   assign ev_rd    = strb_s.sel && strb_s.rd && !strb_p.rd;
   assign ev_wr    = strb_s.sel && strb_s.wr && !strb_p.wr;

   hmap_addr #(.AW(AW), .DW(DW), .OW(OW)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ev_latch),
      .word (bus_s),
      .inc  (inc),
      .addr (cur_addr),
      .space(mem_space),
      .ovl  (mem_ovl)
   );

   hmap_ctrl #(
      .AW(AW), .DW(DW), .PW(PW), .GUARD_EN(GUARD_EN),
      .CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_rd    (ev_rd),
      .ev_wr    (ev_wr),
      .clr_phase(ev_latch),
      .bus_word (bus_s),
      .space    (mem_space),
      .addr     (cur_addr),
      .mem_rdata(mem_rdata),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .inc      (inc),
      .ack      (host_ack),
      .dout     (host_bus_out)
   );

   assign mem_addr    = cur_addr;
   assign host_bus_oe = host_sel && host_rd;
endmodule

// File: rtl/hmap_port_chk.sv
`timescale 1ns/1ps
module hmap_port_chk #(
   parameter int            AW      = 14,
   parameter logic [AW-1:0] CTRL_LO = 14'h3FE0,
   parameter logic [AW-1:0] CTRL_HI = 14'h3FFF
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_ack,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_space,
   input logic [AW-1:0] mem_addr
);
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);                                                 // R4
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !host_ack);                                                // R5
   AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> host_ack);                                     // R5
   AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !host_ack);                                   // R5
   AST_CTRL_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_space) |-> !((mem_addr >= CTRL_LO) && (mem_addr <= CTRL_HI))); // R9
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_space) |=> (mem_addr == $past(mem_addr) + 1'b1));     // R6
endmodule

bind hmap_port hmap_port_chk #(.AW(AW), .CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_ack (host_ack),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_space(mem_space),
   .mem_addr (mem_addr)
);

// File: tb/tb_hmap_port.sv
`timescale 1ns/1ps
module tb_hmap_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        host_sel = 1'b0, host_latch = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_bus_in = '0;
   logic [15:0] host_bus_out;
   logic        host_bus_oe, host_ack, mem_req, mem_we, mem_space;
   logic [13:0] mem_addr;
   logic [7:0]  mem_ovl;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata = '0;

   int vectors = 0, miscompares = 0, req_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   hmap_port dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_latch(host_latch),
      .host_rd(host_rd), .host_wr(host_wr), .host_bus_in(host_bus_in),
      .host_bus_out(host_bus_out), .host_bus_oe(host_bus_oe), .host_ack(host_ack),
      .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space), .mem_addr(mem_addr),
      .mem_ovl(mem_ovl), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // environment memory seen by the port
   logic [23:0] bmem [int];
   always @(posedge clk) begin
      if (rst_n && mem_req) begin
         req_cnt++;
         if (mem_we) bmem[int'({mem_space, mem_addr})] = mem_wdata;
         else mem_rdata <= bmem.exists(int'({mem_space, mem_addr})) ?
                           bmem[int'({mem_space, mem_addr})] : 24'h0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [23:0] emem [int];
   int          m_st = 0;
   bit          m_ack = 1, m_sp = 0, m_ph = 0, m_wr = 0;
   logic [13:0] m_addr = '0;
   logic [7:0]  m_ovl = '0, m_lo = '0;
   logic [15:0] m_hold = '0, m_wb = '0, m_dout = '0;
   int          m_rkey = 0;
   logic [3:0]  hq [$];   // sampled {sel,latch,rd,wr}, newest last
   logic [15:0] bq [$];

   function automatic bit m_ctrl();
      return !m_sp && (m_addr >= 14'h3FE0);
   endfunction
   function automatic bit m_need();
      if (m_ctrl()) return 0;
      if (!m_sp) return 1;
      return m_wr ? m_ph : !m_ph;
   endfunction

   task automatic m_init();
      m_st = 0; m_ack = 1; m_sp = 0; m_ph = 0; m_wr = 0; m_addr = '0; m_ovl = '0;
      m_lo = '0; m_hold = '0; m_wb = '0; m_dout = '0;
      hq.delete(); bq.delete();
      repeat (3) hq.push_back(4'b0);
      repeat (2) bq.push_back(16'h0);
   endtask

   initial m_init();

   always @(posedge clk) begin
      if (!rst_n) m_init();
      else begin
         logic [3:0] cur, prv;
         logic [15:0] w;
         cur = hq[1]; prv = hq[0]; w = bq[0];
         case (m_st)
            0: begin
               if (cur[3] && prv[2] && !cur[2]) begin
                  m_ph = 0;
                  if (!w[15]) begin m_addr = w[13:0]; m_sp = w[14]; end
                  else if (w[14:8] == 7'h0) m_ovl = w[7:0];
               end
               if (cur[3] && ((cur[0] && !prv[0]) || (cur[1] && !prv[1]))) begin
                  m_st = 1; m_wr = cur[0] && !prv[0]; m_wb = w; m_ack = 0;
               end
            end
            1: begin
               bit nd, lst;
               nd = m_need(); lst = !m_sp || m_ph;
               if (nd && m_wr)
                  emem[int'({m_sp, m_addr})] = m_sp ? {m_hold, m_wb[7:0]} : {8'h0, m_wb};
               m_rkey = int'({m_sp, m_addr});
               if (!m_wr && nd) m_st = 2;
               else begin
                  if (!m_wr) m_dout = m_ctrl() ? 16'h0 : {8'h0, m_lo};
                  m_ack = 1; m_st = 0;
               end
               if (m_sp) begin
                  if (m_wr && !m_ph) m_hold = m_wb;
                  m_ph = !m_ph;
               end
               if (lst) m_addr = m_addr + 14'd1;
            end
            default: begin
               logic [23:0] v;
               v = emem.exists(m_rkey) ? emem[m_rkey] : 24'h0;
               m_dout = m_sp ? v[23:8] : v[15:0];
               m_lo = v[7:0]; m_ack = 1; m_st = 0;
            end
         endcase
         void'(hq.pop_front()); hq.push_back({host_sel, host_latch, host_rd, host_wr});
         void'(bq.pop_front()); bq.push_back(host_bus_in);
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         bit ereq;
         ereq = (m_st == 1) && m_need();
         chk(host_ack == m_ack, "R5", "host_ack", host_ack, m_ack);
         chk(mem_req == ereq, "R4", "mem_req", mem_req, ereq);
         chk(mem_addr == m_addr, "R6", "mem_addr", mem_addr, m_addr);
         chk(mem_space == m_sp, "R2", "mem_space", mem_space, m_sp);
         chk(mem_ovl == m_ovl, "R3", "mem_ovl", mem_ovl, m_ovl);
         chk(host_bus_out == m_dout, "R8", "host_bus_out", host_bus_out, m_dout);
         if (ereq) chk(mem_we == m_wr, "R12", "mem_we", mem_we, m_wr);
         if (ereq && m_wr) begin
            logic [23:0] ew;
            ew = m_sp ? {m_hold, m_wb[7:0]} : {8'h0, m_wb};
            chk(mem_wdata == ew, "R7", "mem_wdata", mem_wdata, ew);
         end
      end
   end

   // ---------------- host tasks ----------------
   task automatic wait_done();
      bit seen_low = 0;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         if (!host_ack) seen_low = 1;
         else if (seen_low) return;
      end
      chk(0, "R5", "ack handshake timeout", 0, 1);
   endtask

   task automatic do_latch(input logic [15:0] w);
      @(negedge clk); host_bus_in = w; host_sel = 1; host_latch = 1;
      repeat (4) @(negedge clk); host_latch = 0;
      repeat (4) @(negedge clk); host_sel = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_write(input logic [15:0] d);
      @(negedge clk); host_bus_in = d; host_sel = 1; host_wr = 1;
      wait_done();
      host_wr = 0; host_sel = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_read(output logic [15:0] d);
      @(negedge clk); host_sel = 1; host_rd = 1;
      wait_done();
      d = host_bus_out;
      host_rd = 0; host_sel = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic rd_expect(input logic [15:0] exp, input string req);
      logic [15:0] d;
      do_read(d);
      chk(d == exp, req, "read-back", d, exp);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int rq0;
      #1 rst_n = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(host_ack == 1'b1, "R1", "reset ack", host_ack, 1);
      chk(mem_req == 1'b0, "R1", "reset req", mem_req, 0);
      chk(host_bus_out == 16'h0, "R1", "reset dout", host_bus_out, 0);
      chk(mem_addr == 14'h0 && mem_space == 0 && mem_ovl == 0, "R1", "reset regs",
          {mem_space, mem_ovl, mem_addr}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2 data address setup
      do_latch(16'h0010);
      chk(mem_addr == 14'h0010 && mem_space == 0, "R2", "setup data addr", mem_addr, 14'h10);

      // R4 R5 exact timing of one data write
      @(negedge clk); host_bus_in = 16'h1111; host_sel = 1; host_wr = 1;
      for (int n = 1; n <= 4; n++) begin
         @(negedge clk);
         chk(mem_req == (n == 3), "R4", "req timing", mem_req, n == 3);
         chk(host_ack == (n != 3), "R5", "ack timing", host_ack, n != 3);
      end
      host_wr = 0; host_sel = 0; repeat (4) @(negedge clk);

      // R6 streaming data writes
      do_write(16'h2222);
      do_write(16'h3333);
      chk(mem_addr == 14'h0013, "R6", "auto increment", mem_addr, 14'h13);
      do_latch(16'h0010);
      rd_expect(16'h1111, "R6");
      rd_expect(16'h2222, "R6");
      rd_expect(16'h3333, "R6");

      // R3 overlay setup and a malformed one
      do_latch(16'h8005);
      chk(mem_ovl == 8'h05 && mem_addr == 14'h13, "R3", "overlay load", mem_ovl, 8'h05);
      do_latch(16'h8105);
      chk(mem_ovl == 8'h05 && mem_addr == 14'h13, "R3", "bad overlay ignored", mem_ovl, 8'h05);

      // R7 R8 program words
      do_latch(16'h4020);
      chk(mem_space == 1'b1, "R2", "program space", mem_space, 1);
      rq0 = req_cnt;
      do_write(16'hABCD);
      chk(req_cnt == rq0 && mem_addr == 14'h20, "R7", "first half silent", req_cnt - rq0, 0);
      do_write(16'h00EF);
      chk(mem_addr == 14'h21, "R7", "step after word", mem_addr, 14'h21);
      do_write(16'h1234);
      do_write(16'h0056);
      do_latch(16'h4020);
      rd_expect(16'hABCD, "R8");
      rd_expect(16'h00EF, "R8");
      rd_expect(16'h1234, "R8");
      rd_expect(16'h0056, "R8");

      // R11 setup word resets the half flag
      do_latch(16'h4030);
      do_write(16'h7777);
      do_latch(16'h4030);
      do_write(16'h9999);
      do_write(16'h0011);
      do_latch(16'h4030);
      rd_expect(16'h9999, "R11");
      rd_expect(16'h0011, "R11");

      // R9 control window guard and wrap
      do_latch(16'h3FDF);
      rq0 = req_cnt;
      do_write(16'hAAAA);
      do_write(16'hBBBB);
      chk(req_cnt == rq0 + 1, "R9", "no request into window", req_cnt - rq0, 1);
      chk(mem_addr == 14'h3FE1, "R9", "step inside window", mem_addr, 14'h3FE1);
      do_latch(16'h3FE0);
      rd_expect(16'h0000, "R9");
      do_latch(16'h3FDF);
      rd_expect(16'hAAAA, "R9");
      do_latch(16'h3FFF);
      do_write(16'h5555);
      chk(mem_addr == 14'h0000, "R6", "address wrap", mem_addr, 0);

      // R10 strobes without select
      rq0 = req_cnt;
      @(negedge clk); host_bus_in = 16'hDEAD; host_wr = 1;
      repeat (6) @(negedge clk); host_wr = 0; host_rd = 1;
      repeat (6) @(negedge clk); host_rd = 0;
      repeat (4) @(negedge clk);
      chk(req_cnt == rq0 && mem_addr == 14'h0 && host_ack, "R10", "no-select ignored",
          req_cnt - rq0, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule